// File: doc/BRIEF.md
# Fractional Output Clock Divider with Triangle Spread

This block sits in the clock domain of a fast oscillator and turns it into a slower output clock. Each divided period lasts a whole number of fast cycles. An integer ratio sets the base length. A 24-bit fraction, added into a phase accumulator once per period, makes some periods one cycle longer, so the average ratio is the integer plus fraction/2^24. The output pair toggles once at the end of every divided period. The output frequency is therefore the input frequency divided by twice the average period.

A triangle modulator can add a slowly varying offset to the fraction, which spreads the output spectrum. A step timer in input-clock cycles sets its rate, independent of the output frequency. The offset climbs by a fixed increment up to a programmed peak, falls back to zero, and repeats. Any carry out of the fraction plus offset adds one cycle to the integer part. Integer-only mode removes the fraction and the offset from the ratio. The second output either follows the first or is its inverse. An enable turns both outputs off.

Control state machine: `ST_OFF` (outputs low, accumulator held at zero) moves to `ST_RUN` on *enable-seen*, which loads the first period. `ST_RUN` stays in `ST_RUN` on *period-end*, which toggles the output and loads the next period. It returns to `ST_OFF` on *enable-dropped*. Modulator state machine: `TRI_UP` moves to `TRI_DOWN` on *peak-reached*. `TRI_DOWN` moves to `TRI_UP` on *floor-reached*. Both are forced to `TRI_UP` with a zero offset while spread is off.

Top module: `frac_out_divider`

## Requirements
- R1: During reset and after it, while `out_en` is 0, `clk_out` and `clk_out_n` are both 0.
- R2: With `int_only` = 1, every divided period is exactly the clamped integer ratio. `frac_div` and all spread inputs have no effect.
- R3: An `int_div` value of 0 or 1 is treated as 2.
- R4: With `int_only` = 0, the accumulator starts at 0 when the output is enabled. Each period computes s = acc + fraction, where the fraction is `frac_div` plus the spread offset. The period is then the clamped integer, plus bit 24 of that fraction, plus bit 24 of s. The accumulator then takes s mod 2^24.
- R5: A ratio change takes effect only when a period is loaded. The period in progress keeps its length.
- R6: Lowering `out_en` drives both outputs to 0 at the next clock edge. After re-enabling, the first toggle comes P0+1 edges after the last edge that sampled `out_en` low, where P0 is the first period computed by R4.
- R7: While enabled, `clk_out_n` equals `clk_out` when `comp_invert` = 0 and equals its inverse when `comp_invert` = 1.
- R8: With spread on, the offset rises by `ssc_incr` once every max(`ssc_step_len`,1) cycles until it reaches `ssc_peak`. It then falls by the same step to 0 and repeats. With `frac_div` = 0 and a non-zero peak, periods take both the integer length and the integer length plus 1. With the peak at 0, every period is the integer length.
- R9: Once spread is switched off, the offset is 0 and the ratio is unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Output enable |
| int_only | input | 1 | 1: integer division only |
| int_div | input | 12 | Integer part of the ratio |
| frac_div | input | 24 | Fractional part of the ratio, in units of 2^-24 |
| ssc_en | input | 1 | Spread modulation enable |
| ssc_step_len | input | 16 | Cycles between modulator steps (0 acts as 1) |
| ssc_peak | input | 24 | Top of the triangle offset |
| ssc_incr | input | 24 | Offset change per modulator step |
| comp_invert | input | 1 | 1: complementary output inverted |
| clk_out | output | 1 | True divided output |
| clk_out_n | output | 1 | Complementary divided output |

## Verification
Each toggle is registered, so a period of P is seen as toggles exactly P edges apart. The first toggle after enabling lands P0+1 edges after the last edge that sampled the enable low. The bench timestamps every posedge and samples only on negedges, then compares toggle-to-toggle gaps with periods from its own accumulator model. A disable shows up on the negedge right after the next posedge. A polarity change on the complementary output is combinational and is checked on the following negedge. A ratio written mid-period is expected to change only the gap after the next toggle.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
    localparam int DEF_INT_W  = 12;
    localparam int DEF_FRAC_W = 24;
    localparam int DEF_STEP_W = 16;

    typedef enum logic {ST_OFF = 1'b0, ST_RUN = 1'b1} div_state_e;
    typedef enum logic {TRI_UP = 1'b0, TRI_DOWN = 1'b1} tri_dir_e;
endpackage

// File: rtl/fdiv_spread.sv
module fdiv_spread
    import frac_div_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int STEP_W = DEF_STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ssc_en,
    input  logic [STEP_W-1:0] step_len,
    input  logic [FRAC_W-1:0] peak,
    input  logic [FRAC_W-1:0] incr,
    output logic [FRAC_W-1:0] offset
);
    tri_dir_e          dir_q, dir_d;
    logic [FRAC_W-1:0] off_q, off_d;
    logic [STEP_W-1:0] timer_q, step_eff;
    logic [FRAC_W:0]   rise;
    logic              tick;

    always_comb begin
        step_eff = (step_len == '0) ? STEP_W'(1) : step_len;
        tick     = ssc_en && (timer_q >= step_eff - STEP_W'(1));
        rise     = {1'b0, off_q} + {1'b0, incr};
    end

    always_comb begin
        dir_d = dir_q;
        off_d = off_q;
        if (!ssc_en) begin
            dir_d = TRI_UP;
            off_d = '0;
        end else if (tick) begin
            unique case (dir_q)
                TRI_UP: begin
                    if (rise >= {1'b0, peak}) begin
                        off_d = peak;
                        dir_d = TRI_DOWN;
                    end else begin
                        off_d = rise[FRAC_W-1:0];
                    end
                end
                TRI_DOWN: begin
                    if (off_q <= incr) begin
                        off_d = '0;
                        dir_d = TRI_UP;
                    end else begin
                        off_d = off_q - incr;
                    end
                end
                default: dir_d = TRI_UP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= TRI_UP;
            off_q   <= '0;
            timer_q <= '0;
        end else begin
            dir_q   <= dir_d;
            off_q   <= off_d;
            timer_q <= (!ssc_en || tick) ? '0 : timer_q + STEP_W'(1);
        end
    end

    assign offset = off_q;

    assert_rise_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dir_q) == TRI_UP && dir_q == TRI_UP && $past(ssc_en) && ssc_en)
        |-> off_q >= $past(off_q));

    assert_fall_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dir_q) == TRI_DOWN && dir_q == TRI_DOWN && $past(ssc_en))
        |-> off_q <= $past(off_q));

    assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ssc_en |=> (offset == '0 && dir_q == TRI_UP));
endmodule

// File: rtl/fdiv_ratio.sv
module fdiv_ratio
    import frac_div_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int CNT_W  = DEF_INT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [INT_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] frac_div,
    input  logic              int_only,
    input  logic [FRAC_W-1:0] offset,
    output logic [CNT_W-1:0]  period
);
    logic [FRAC_W-1:0] acc_q, acc_base;
    logic [FRAC_W:0]   frac_sum, acc_sum;
    logic [INT_W-1:0]  int_eff;

    always_comb begin
        int_eff  = (int_div < INT_W'(2)) ? INT_W'(2) : int_div;
        frac_sum = int_only ? '0 : ({1'b0, frac_div} + {1'b0, offset});
        acc_base = restart ? '0 : acc_q;
        acc_sum  = {1'b0, acc_base} + {1'b0, frac_sum[FRAC_W-1:0]};
        period   = CNT_W'(int_eff) + CNT_W'(frac_sum[FRAC_W]) + CNT_W'(acc_sum[FRAC_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (advance) acc_q <= acc_sum[FRAC_W-1:0];
        else if (restart) acc_q <= '0;
    end

    assert_int_only_freezes_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && int_only && !restart) |=> acc_q == $past(acc_q));
endmodule

// File: rtl/fdiv_fsm.sv
module fdiv_fsm
    import frac_div_pkg::*;
#(
    parameter int CNT_W = DEF_INT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  logic             comp_invert,
    input  logic [CNT_W-1:0] period,
    output logic             load,
    output logic             restart,
    output logic             clk_out,
    output logic             clk_out_n
);
    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             tgl_q;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_OFF: if (out_en) begin
                state_d = ST_RUN;
                load    = 1'b1;
            end
            ST_RUN: begin
                if (!out_en)                     state_d = ST_OFF;
                else if (cnt_q == CNT_W'(1))     load    = 1'b1;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else if (state_d == ST_OFF) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else if (load) begin
            cnt_q <= period;
            if (state_q == ST_RUN) tgl_q <= ~tgl_q;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        restart   = (state_q == ST_OFF);
        clk_out   = tgl_q;
        clk_out_n = (state_q == ST_RUN) ? (tgl_q ^ comp_invert) : 1'b0;
    end

    assert_run_cnt_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |-> cnt_q != '0);

    assert_toggle_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RUN && state_q == ST_RUN && tgl_q != $past(tgl_q))
        |-> $past(cnt_q) == CNT_W'(1));

    assert_loaded_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && state_q == ST_RUN) |-> cnt_q >= CNT_W'(2));

    assert_off_outputs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_OFF |-> (!clk_out && !clk_out_n));
endmodule

// File: rtl/frac_out_divider.sv
module frac_out_divider
    import frac_div_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int STEP_W = DEF_STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_en,
    input  logic              int_only,
    input  logic [INT_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] frac_div,
    input  logic              ssc_en,
    input  logic [STEP_W-1:0] ssc_step_len,
    input  logic [FRAC_W-1:0] ssc_peak,
    input  logic [FRAC_W-1:0] ssc_incr,
    input  logic              comp_invert,
    output logic              clk_out,
    output logic              clk_out_n
);
    localparam int CNT_W = INT_W + 2;

    logic [FRAC_W-1:0] offset;
    logic [CNT_W-1:0]  period;
    logic              load, restart;

    fdiv_spread #(.FRAC_W(FRAC_W), .STEP_W(STEP_W)) spread_i (
        .clk(clk), .rst_n(rst_n), .ssc_en(ssc_en), .step_len(ssc_step_len),
        .peak(ssc_peak), .incr(ssc_incr), .offset(offset)
    );

    fdiv_ratio #(.INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) ratio_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(load),
        .int_div(int_div), .frac_div(frac_div), .int_only(int_only),
        .offset(offset), .period(period)
    );

    fdiv_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .comp_invert(comp_invert),
        .period(period), .load(load), .restart(restart),
        .clk_out(clk_out), .clk_out_n(clk_out_n)
    );
endmodule

// File: tb/frac_out_divider_tb_top.sv
module frac_out_divider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        out_en = 1'b0, int_only = 1'b0, ssc_en = 1'b0, comp_invert = 1'b0;
    logic [11:0] int_div = 12'd4;
    logic [23:0] frac_div = '0, ssc_peak = '0, ssc_incr = '0;
    logic [15:0] ssc_step_len = 16'd1;
    logic        clk_out, clk_out_n;

    frac_out_divider dut_i (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .int_only(int_only),
        .int_div(int_div), .frac_div(frac_div), .ssc_en(ssc_en),
        .ssc_step_len(ssc_step_len), .ssc_peak(ssc_peak), .ssc_incr(ssc_incr),
        .comp_invert(comp_invert), .clk_out(clk_out), .clk_out_n(clk_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;
    logic prev_out = 1'b0;

    task automatic check_eq(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint clamp_int(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    function automatic longint model_step(ref longint acc, input int n, input longint fr, input bit io);
        longint s;
        s   = acc + (io ? 0 : fr);
        acc = s & 64'hFFFFFF;
        return clamp_int(n) + (s >> 24);
    endfunction

    task automatic wait_toggle(output int unsigned t);
        forever begin
            @(negedge clk);
            if (clk_out !== prev_out) begin
                prev_out = clk_out;
                t = cyc;
                break;
            end
        end
    endtask

    task automatic start_run(output int unsigned c0);
        @(negedge clk); out_en = 1'b0;
        @(negedge clk); @(negedge clk);
        prev_out = clk_out;
        c0 = cyc;
        out_en = 1'b1;
    endtask

    task automatic run_model(input string tag, input int n, input longint fr, input bit io, input int count);
        longint acc = 0;
        longint p;
        int unsigned c0, t, tp;
        int_div = 12'(n); frac_div = 24'(fr); int_only = io;
        start_run(c0);
        p = model_step(acc, n, fr, io);
        wait_toggle(t);
        check_eq({tag, " R6 first toggle"}, t - c0, p + 1);
        tp = t;
        for (int k = 0; k < count; k++) begin
            p = model_step(acc, n, fr, io);
            wait_toggle(t);
            check_eq(tag, t - tp, p);
            tp = t;
        end
    endtask

    initial begin
        int unsigned t1, t2, t3, c0;
        int cnt_long;
        bit ok;
        void'($urandom(32'd20240611));

        // R1: reset state
        #(CLK_PERIOD*2);
        check_eq("R1 clk_out in reset", clk_out, 0);
        check_eq("R1 clk_out_n in reset", clk_out_n, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1 clk_out disabled", clk_out, 0);
        check_eq("R1 clk_out_n disabled", clk_out_n, 0);

        // R2: integer only, fraction and spread ignored
        ssc_en = 1'b1; ssc_peak = 24'hFFFFFF; ssc_incr = 24'h400000; ssc_step_len = 16'd2;
        run_model("R2 int-only", 7, 24'hABCDEF, 1'b1, 12);
        ssc_en = 1'b0;

        // R3: clamp of 0 and 1
        run_model("R3 clamp int=0", 0, 0, 1'b1, 6);
        run_model("R3 clamp int=1", 1, 24'h123456, 1'b1, 6);
        run_model("R3 R4 clamp int=1 frac", 1, 24'h800000, 1'b0, 8);

        // R4: directed fractions
        run_model("R4 half", 3, 24'h800000, 1'b0, 10);
        run_model("R4 near one", 4, 24'hFFFFFF, 1'b0, 10);
        run_model("R4 tiny", 2, 24'h000001, 1'b0, 6);

        // R4: random ratios
        for (int i = 0; i < 8; i++) begin
            int n;
            longint fr;
            bit io;
            n  = 2 + int'($urandom % 14);
            fr = longint'($urandom & 32'hFFFFFF);
            io = ($urandom % 4) == 0;
            run_model(io ? "R2 random int-only" : "R4 random frac", n, fr, io, 20);
        end

        // R5: ratio change mid-period applies at the next load only
        int_only = 1'b1; int_div = 12'd6;
        start_run(c0);
        wait_toggle(t1);
        @(negedge clk); @(negedge clk);
        int_div = 12'd9;
        wait_toggle(t2);
        check_eq("R5 period in progress", t2 - t1, 6);
        wait_toggle(t3);
        check_eq("R5 new period", t3 - t2, 9);

        // R7: complementary polarity
        comp_invert = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check_eq("R7 aligned", clk_out_n, clk_out);
        end
        comp_invert = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check_eq("R7 inverted", clk_out_n, !clk_out);
        end

        // R6: disable forces both low at the next edge
        wait_toggle(t1);
        out_en = 1'b0;
        @(negedge clk);
        check_eq("R6 clk_out off", clk_out, 0);
        check_eq("R6 clk_out_n off", clk_out_n, 0);
        prev_out = clk_out;
        comp_invert = 1'b0;

        // R8: spread produces lengthened periods
        int_only = 1'b0; frac_div = '0; int_div = 12'd5;
        ssc_en = 1'b1; ssc_step_len = 16'd3; ssc_peak = 24'h800000; ssc_incr = 24'h100000;
        start_run(c0);
        wait_toggle(t1);
        cnt_long = 0; ok = 1;
        for (int k = 0; k < 60; k++) begin
            wait_toggle(t2);
            if ((t2 - t1) != 5 && (t2 - t1) != 6) begin
                ok = 0;
                check_eq("R8 spread period bound", t2 - t1, 5);
            end
            if ((t2 - t1) == 6) cnt_long++;
            t1 = t2;
        end
        check_eq("R8 spread bounds held", ok, 1);
        check_eq("R8 spread lengthens some periods", cnt_long > 0, 1);

        // R8: zero peak gives no modulation
        ssc_peak = '0;
        for (int k = 0; k < 12; k++) wait_toggle(t1);
        for (int k = 0; k < 15; k++) begin
            wait_toggle(t2);
            check_eq("R8 zero peak", t2 - t1, 5);
            t1 = t2;
        end

        // R9: spread off leaves ratio unmodified
        ssc_peak = 24'hFFFFFF; ssc_incr = 24'hFFFFFF; ssc_step_len = 16'd0;
        repeat (20) @(negedge clk);
        ssc_en = 1'b0;
        wait_toggle(t1); wait_toggle(t1);
        for (int k = 0; k < 15; k++) begin
            wait_toggle(t2);
            check_eq("R9 spread off", t2 - t1, 5);
            t1 = t2;
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYC);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule